// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block links one narrow port, called A, to a pair of narrow ports, called low-half and high-half, that together form a word twice as wide. Going from A to the wide side, each half has its own register with an active-low load enable. A producer can therefore present two narrow words one after the other, load the first into the low half and the second into the high half, and a consumer then reads both as one wide word. Going from the wide side to A, a select input chooses one half. That half's input is captured into a single return register on every rising clock edge, and the return register feeds the A output.

Each of the three ports has its own active-low output enable. The enables are sampled into registers on the clock, so a port starts or stops driving only after an edge. Every port is modelled as an always-valued data output plus a drive flag. When the block is itself driving a port, it takes that port's incoming value from its own output register and ignores the external input, because a shared bus carries the driven value. An optional synchronous reset clears the enable registers, and optionally the data registers, so that every port starts undriven.

Top module: `bus_pack_xchg`

## Requirements
- R1: On a rising edge where `lo_load_n` is 0, the low-half register (`blo_out`) takes the A-side value.
- R2: On a rising edge where `hi_load_n` is 0, the high-half register (`bhi_out`) takes the A-side value, independently of the low half.
- R3: A half register whose load enable is 1 at an edge keeps its previous value.
- R4: Two narrow words loaded one after the other into the low half and then the high half read back as the wide word {`bhi_out`, `blo_out`}, with the high half in the upper bits.
- R5: On every rising edge, the return register (`a_out`) captures the low-half input when `pick_lo` is 1 and the high-half input when `pick_lo` is 0.
- R6: Between clock edges, no output changes, whatever the data, select, load and enable inputs do.
- R7: The enable inputs are active low. A drive flag is 1 exactly when its enable input was 0 at the preceding rising edge, so a new enable takes effect one cycle after it is applied.
- R8: While `rst` is 1 at an edge, all three drive flags become 0 and all data registers become 0, whatever the enable inputs are.
- R9: While `a_drv` is 1, the half registers load the value on `a_out` and ignore `a_in`.
- R10: While a half's drive flag is 1, the return register takes that half's `*_out` value when the half is selected, and ignores that half's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WORD_W | Value received on the narrow port |
| a_out | output | WORD_W | Return register contents |
| a_drv | output | 1 | Narrow port is driven when 1 |
| blo_in | input | WORD_W | Value received on the low half |
| bhi_in | input | WORD_W | Value received on the high half |
| blo_out | output | WORD_W | Low-half register contents |
| bhi_out | output | WORD_W | High-half register contents |
| blo_drv | output | 1 | Low half is driven when 1 |
| bhi_drv | output | 1 | High half is driven when 1 |
| lo_load_n | input | 1 | Low-half load enable, active low |
| hi_load_n | input | 1 | High-half load enable, active low |
| pick_lo | input | 1 | Return path source: 1 selects low half, 0 selects high half |
| a_oe_n | input | 1 | Narrow port output enable, active low |
| blo_oe_n | input | 1 | Low-half output enable, active low |
| bhi_oe_n | input | 1 | High-half output enable, active low |

## Verification
The bench builds the block with `WORD_W` = 12, `HAS_RST` = 1 and `CLR_DATA` = 1. With the reset variant selected, every register starts from a known zero state, which makes checks from the first cycle possible and allows a reset issued mid-operation to be checked against enables that are held active. Twelve-bit words such as 0x123 and 0xABC make a swap of the two halves, or a half that loaded when it should have held, show up in the combined 24-bit value.

// File: rtl/bus_pack_xchg_pkg.sv
package bus_pack_xchg_pkg;

   // number of narrow halves forming the wide side
   localparam int unsigned HALVES = 2;

   // drive flags for the three ports, 1 = port driven
   typedef struct packed {
      logic a;
      logic hi;
      logic lo;
   } drive_t;

   // convert active-low enables to drive flags
   function automatic drive_t oe_to_drive(input logic oe_a_n,
                                          input logic oe_lo_n,
                                          input logic oe_hi_n);
      drive_t d;
      d.a  = ~oe_a_n;
      d.lo = ~oe_lo_n;
      d.hi = ~oe_hi_n;
      return d;
   endfunction

endpackage

// File: rtl/xchg_oe_reg.sv
module xchg_oe_reg
   import bus_pack_xchg_pkg::*;
#(
   parameter int unsigned HAS_RST = 1
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   a_oe_n,
   input  logic   lo_oe_n,
   input  logic   hi_oe_n,
   output drive_t drv
);

   drive_t drv_d;

   always_comb begin
      drv_d = oe_to_drive(a_oe_n, lo_oe_n, hi_oe_n);
   end

   generate
      if (HAS_RST != 0) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst) drv <= '0;
            else     drv <= drv_d;
         end

         // R8
         oe_reset_chk: assert property (@(posedge clk)
            rst |=> (drv == '0));
      end else begin : g_norst
         logic rst_unused;
         assign rst_unused = rst;
         always_ff @(posedge clk) begin
            drv <= drv_d;
         end
      end
   endgenerate

   // R7
   oe_latency_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (drv.a == !$past(a_oe_n)) && (drv.lo == !$past(lo_oe_n))
               && (drv.hi == !$past(hi_oe_n)));

endmodule

// File: rtl/xchg_half_reg.sv
module xchg_half_reg #(
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned CLR_DATA = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_n,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);

   generate
      if (CLR_DATA != 0) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)          q <= '0;
            else if (!load_n) q <= d;
         end
      end else begin : g_noclr
         logic rst_unused;
         assign rst_unused = rst;
         always_ff @(posedge clk) begin
            if (!load_n) q <= d;
         end
      end
   endgenerate

   // R3
   half_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && load_n) |=> $stable(q));

   // R1 / R2
   half_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && !load_n) |=> (q == $past(d)));

endmodule

// File: rtl/xchg_return_reg.sv
module xchg_return_reg #(
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned CLR_DATA = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pick_lo,
   input  logic [WORD_W-1:0] lo_src,
   input  logic [WORD_W-1:0] hi_src,
   output logic [WORD_W-1:0] q
);

   logic [WORD_W-1:0] chosen;

   always_comb begin
      chosen = pick_lo ? lo_src : hi_src;
   end

   generate
      if (CLR_DATA != 0) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= chosen;
         end
      end else begin : g_noclr
         logic rst_unused;
         assign rst_unused = rst;
         always_ff @(posedge clk) begin
            q <= chosen;
         end
      end
   endgenerate

   // R5
   ret_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && pick_lo) |=> (q == $past(lo_src)));

   // R5
   ret_hi_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && !pick_lo) |=> (q == $past(hi_src)));

endmodule

// File: rtl/bus_pack_xchg.sv
module bus_pack_xchg
   import bus_pack_xchg_pkg::*;
#(
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned HAS_RST  = 1,
   parameter int unsigned CLR_DATA = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] a_in,
   output logic [WORD_W-1:0] a_out,
   output logic              a_drv,
   input  logic [WORD_W-1:0] blo_in,
   input  logic [WORD_W-1:0] bhi_in,
   output logic [WORD_W-1:0] blo_out,
   output logic [WORD_W-1:0] bhi_out,
   output logic              blo_drv,
   output logic              bhi_drv,
   input  logic              lo_load_n,
   input  logic              hi_load_n,
   input  logic              pick_lo,
   input  logic              a_oe_n,
   input  logic              blo_oe_n,
   input  logic              bhi_oe_n
);

   localparam int unsigned WIDE_W = WORD_W * HALVES;

   // elaboration-time parameter checks
   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("bus_pack_xchg: WORD_W must be at least 1");
      end
      if (HAS_RST > 1) begin : g_bad_rst
         $error("bus_pack_xchg: HAS_RST must be 0 or 1");
      end
      if (CLR_DATA > 1) begin : g_bad_clr
         $error("bus_pack_xchg: CLR_DATA must be 0 or 1");
      end
   endgenerate

   drive_t                         drv;
   logic [WORD_W-1:0]              a_q;
   logic [WORD_W-1:0]              a_side;
   logic [HALVES-1:0]              load_n_vec;
   logic [HALVES-1:0][WORD_W-1:0]  half_q;
   logic [HALVES-1:0][WORD_W-1:0]  half_in;
   logic [HALVES-1:0]              half_drv;
   logic [HALVES-1:0][WORD_W-1:0]  half_side;
   logic [WIDE_W-1:0]              wide_word;

   xchg_oe_reg #(
      .HAS_RST (HAS_RST)
   ) u_oe (
      .clk     (clk),
      .rst     (rst),
      .a_oe_n  (a_oe_n),
      .lo_oe_n (blo_oe_n),
      .hi_oe_n (bhi_oe_n),
      .drv     (drv)
   );

   // a driven port carries the block's own value, not the external one
   always_comb begin
      a_side = drv.a ? a_q : a_in;
   end

   assign load_n_vec = {hi_load_n, lo_load_n};
   assign half_in    = {bhi_in, blo_in};
   assign half_drv   = {drv.hi, drv.lo};

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         xchg_half_reg #(
            .WORD_W   (WORD_W),
            .CLR_DATA (CLR_DATA)
         ) u_half (
            .clk    (clk),
            .rst    (rst),
            .load_n (load_n_vec[h]),
            .d      (a_side),
            .q      (half_q[h])
         );

         always_comb begin
            half_side[h] = half_drv[h] ? half_q[h] : half_in[h];
         end
      end
   endgenerate

   xchg_return_reg #(
      .WORD_W   (WORD_W),
      .CLR_DATA (CLR_DATA)
   ) u_ret (
      .clk     (clk),
      .rst     (rst),
      .pick_lo (pick_lo),
      .lo_src  (half_side[0]),
      .hi_src  (half_side[1]),
      .q       (a_q)
   );

   assign wide_word = half_q;
   assign a_out     = a_q;
   assign a_drv     = drv.a;
   assign blo_out   = wide_word[WORD_W-1:0];
   assign bhi_out   = wide_word[WIDE_W-1:WORD_W];
   assign blo_drv   = drv.lo;
   assign bhi_drv   = drv.hi;

   // R9
   a_driven_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && a_drv && !lo_load_n) |=> (blo_out == $past(a_out)));

   // R10
   lo_driven_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && blo_drv && pick_lo) |=> (a_out == $past(blo_out)));

   // R10
   hi_driven_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && bhi_drv && !pick_lo) |=> (a_out == $past(bhi_out)));

endmodule

// File: tb/bus_pack_xchg_tb.sv
`timescale 1ns/1ps
module bus_pack_xchg_tb;

   localparam int unsigned W = 12;

   typedef struct {
      string        tag;
      logic [W-1:0] a;
      logic [W-1:0] lo;
      logic [W-1:0] hi;
      logic         da;
      logic         dlo;
      logic         dhi;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0, blo_in = '0, bhi_in = '0;
   logic [W-1:0] a_out, blo_out, bhi_out;
   logic         a_drv, blo_drv, bhi_drv;
   logic         lo_load_n = 1'b1, hi_load_n = 1'b1, pick_lo = 1'b0;
   logic         a_oe_n = 1'b1, blo_oe_n = 1'b1, bhi_oe_n = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t         sb[$];
   logic [W-1:0] m_a = '0, m_lo = '0, m_hi = '0;
   logic         m_da = 1'b0, m_dlo = 1'b0, m_dhi = 1'b0;

   always #2.5 clk = ~clk;

   bus_pack_xchg #(.WORD_W(W), .HAS_RST(1), .CLR_DATA(1)) u_dut (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .blo_in(blo_in), .bhi_in(bhi_in), .blo_out(blo_out), .bhi_out(bhi_out),
      .blo_drv(blo_drv), .bhi_drv(bhi_drv), .lo_load_n(lo_load_n),
      .hi_load_n(hi_load_n), .pick_lo(pick_lo), .a_oe_n(a_oe_n),
      .blo_oe_n(blo_oe_n), .bhi_oe_n(bhi_oe_n)
   );

   task automatic cmp(input string tag, input string fld,
                      input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and queue what the next edge must give
   task automatic step(input string tag, input logic r,
                       input logic lln, input logic hln, input logic pl,
                       input logic oa, input logic ol, input logic oh,
                       input logic [W-1:0] ai, input logic [W-1:0] li,
                       input logic [W-1:0] hi);
      exp_t e;
      logic [W-1:0] a_e, l_e, h_e;
      @(negedge clk);
      rst = r; lo_load_n = lln; hi_load_n = hln; pick_lo = pl;
      a_oe_n = oa; blo_oe_n = ol; bhi_oe_n = oh;
      a_in = ai; blo_in = li; bhi_in = hi;
      #1;
      // R6: inputs changed, no edge yet, outputs unchanged
      cmp("R6", "a_out", a_out, m_a);
      cmp("R6", "blo_out", blo_out, m_lo);
      cmp("R6", "bhi_out", bhi_out, m_hi);
      // R7: new enables not yet visible before the edge
      cmp("R7", "drive flags", {a_drv, blo_drv, bhi_drv}, {m_da, m_dlo, m_dhi});
      a_e = m_da  ? m_a  : ai;
      l_e = m_dlo ? m_lo : li;
      h_e = m_dhi ? m_hi : hi;
      if (r) begin
         m_a = '0; m_lo = '0; m_hi = '0;
         m_da = 1'b0; m_dlo = 1'b0; m_dhi = 1'b0;
      end else begin
         if (!lln) m_lo = a_e;
         if (!hln) m_hi = a_e;
         m_a   = pl ? l_e : h_e;
         m_da  = !oa;
         m_dlo = !ol;
         m_dhi = !oh;
      end
      e.tag = tag; e.a = m_a; e.lo = m_lo; e.hi = m_hi;
      e.da = m_da; e.dlo = m_dlo; e.dhi = m_dhi;
      sb.push_back(e);
   endtask

   // monitor: compare the queued expectation just after each edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            cmp(e.tag, "a_out", a_out, e.a);
            cmp(e.tag, "blo_out", blo_out, e.lo);
            cmp(e.tag, "bhi_out", bhi_out, e.hi);
            // R4: wide word is high half over low half
            cmp(e.tag, "R4 wide word", {bhi_out, blo_out}, {e.hi, e.lo});
            cmp(e.tag, "R7 a_drv", a_drv, e.da);
            cmp(e.tag, "R7 blo_drv", blo_drv, e.dlo);
            cmp(e.tag, "R7 bhi_drv", bhi_drv, e.dhi);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R8: reset with enables requested active
      step("R8 reset", 1, 0, 0, 1, 0, 0, 0, 12'hF0F, 12'h0AA, 12'h055);
      step("R8 reset", 1, 1, 1, 0, 1, 1, 1, 12'h000, 12'h000, 12'h000);
      // R1: first word into low half
      step("R1 load low", 0, 0, 1, 1, 1, 1, 1, 12'h123, 12'h000, 12'h000);
      // R2: second word into high half, low holds
      step("R2 load high", 0, 1, 0, 1, 1, 1, 1, 12'hABC, 12'h000, 12'h000);
      // R3 / R4: both hold, wide word is ABC123
      step("R3 hold", 0, 1, 1, 1, 1, 1, 1, 12'hFFF, 12'h000, 12'h000);
      step("R4 pair", 0, 1, 1, 1, 1, 1, 1, 12'h5A5, 12'h000, 12'h000);
      step("R1 both load", 0, 0, 0, 1, 1, 1, 1, 12'h5A5, 12'h000, 12'h000);
      // R5: return path source selection
      step("R5 pick low", 0, 1, 1, 1, 1, 1, 1, 12'h000, 12'h111, 12'h222);
      step("R5 pick high", 0, 1, 1, 0, 1, 1, 1, 12'h000, 12'h111, 12'h222);
      // R7: enable A, one cycle latency
      step("R7 enable A", 0, 1, 1, 0, 0, 1, 1, 12'h000, 12'h333, 12'h444);
      // R9: A driven, low half loads a_out not a_in
      step("R9 A driven", 0, 0, 1, 0, 0, 1, 1, 12'h0F0, 12'h333, 12'h444);
      step("R9 A driven high", 0, 1, 0, 0, 1, 0, 0, 12'h0F0, 12'h555, 12'h666);
      // R10: both halves driven, return reg ignores their inputs
      step("R10 low driven", 0, 1, 1, 1, 1, 0, 0, 12'h000, 12'h777, 12'h888);
      step("R10 high driven", 0, 1, 1, 0, 1, 1, 1, 12'h000, 12'h999, 12'hAAA);
      step("R5 undriven", 0, 1, 1, 1, 1, 1, 1, 12'h000, 12'hBBB, 12'hCCC);
      // R8: reset mid-operation with enables held low
      step("R7 all enable", 0, 0, 0, 1, 0, 0, 0, 12'h246, 12'h135, 12'h864);
      step("R8 mid reset", 1, 0, 0, 1, 0, 0, 0, 12'h246, 12'h135, 12'h864);
      step("R7 after reset", 0, 1, 1, 1, 0, 0, 0, 12'h000, 12'h000, 12'h000);
      step("R3 idle", 0, 1, 1, 1, 1, 1, 1, 12'h000, 12'h000, 12'h000);
      @(posedge clk);
      #2;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule